// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block decides, at each instruction boundary of a small processor, whether an interrupt is taken and where execution goes next. Five request sources feed it. A non-maskable request takes priority over all others. Three restart requests (A, B and C) each have a fixed vector address. A general external request has no fixed vector and is answered with an acknowledge pulse, during which outside logic drives an instruction byte, such as a restart opcode, onto the data bus.

Two gates qualify the maskable sources. The first is a global interrupt enable, which the processor sets and clears with enable and disable commands. The second is a three-bit mask register that blocks each restart source on its own. Restart C is captured by a rising-edge latch, so a short pulse is not lost while the source is blocked. The other sources are level-sensitive. When a maskable interrupt is accepted, the global enable clears, and the handler must set it again.

Top module: `irq_vector_ctrl`

## Requirements
- R1: The vectors are fixed: 0x0024 for the non-maskable source, 0x002C for restart A, 0x0034 for restart B and 0x003C for restart C. `vector_o` reads 0x0000 whenever `take_o` is low.
- R2: When several qualified requests are present at a boundary, the winner follows this order, from highest to lowest: non-maskable, restart C, restart B, restart A, external.
- R3: The non-maskable source is taken whenever it is high at a boundary. It does not depend on the global enable or on any mask bit.
- R4: The external request is taken only while the global enable is set. Taking it raises `ext_ack_o` for one cycle, together with `take_o`, and `vector_o` reads 0x0000.
- R5: A restart source is taken only when the global enable is set and its mask bit is 0. The mask bits are bit 0 for A, bit 1 for B and bit 2 for C. Bit value 1 blocks the source. `mask_we_i` loads `mask_i`.
- R6: A rising edge on `irq_c_i` is held pending, whatever the gates are, until restart C is taken. Taking it clears the pending state. A level source that drops before a qualifying boundary leaves nothing pending.
- R7: Requests are evaluated only in cycles where `boundary_i` is high. `take_o` rises in the cycle after that boundary and stays high for exactly one cycle.
- R8: Accepting any maskable source clears the global enable. Accepting the non-maskable source leaves the global enable unchanged.
- R9: After reset, the global enable is clear, all three mask bits are set, the edge latch is empty, and all outputs are low.
- R10: `ien_clr_i` clears the global enable. When `ien_set_i` and `ien_clr_i` are both high in the same cycle, the clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| nmi_i | input | 1 | Non-maskable request, level |
| irq_a_i | input | 1 | Restart A request, level |
| irq_b_i | input | 1 | Restart B request, level |
| irq_c_i | input | 1 | Restart C request, rising-edge latched |
| ext_req_i | input | 1 | External request, level |
| ien_set_i | input | 1 | Set-global-enable command |
| ien_clr_i | input | 1 | Clear-global-enable command |
| mask_we_i | input | 1 | Mask register write strobe |
| mask_i | input | 3 | New mask bits {C,B,A}; 1 blocks the source |
| boundary_i | input | 1 | Instruction-boundary strobe |
| take_o | output | 1 | Interrupt accepted (one-cycle pulse) |
| vector_o | output | 16 | Vector address of the accepted source |
| ext_ack_o | output | 1 | Acknowledge pulse for the external request |

## Verification
Every internal state fault reaches the ports at the next boundary at which a request is present. A stuck global enable produces either a second maskable take with no re-enable in between, or no take at all after an enable command. A wrong mask bit lets a blocked restart through, or stops an unblocked one, at the first boundary. An edge latch that fails to clear makes restart C win again at the next enabled boundary. An edge latch that fails to set is seen only later, when the source becomes unblocked and nothing is taken. The directed scenarios are built so that each of these faults changes `take_o` or `vector_o` within one or two boundaries.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
   // Source slots, listed from highest to lowest priority
   localparam int unsigned SLOT_NMI = 0;
   localparam int unsigned SLOT_C   = 1;
   localparam int unsigned SLOT_B   = 2;
   localparam int unsigned SLOT_A   = 3;
   localparam int unsigned SLOT_EXT = 4;
   localparam int unsigned NUM_SLOT = 5;
   // Restart inputs, listed by mask bit position
   localparam int unsigned NUM_RST  = 3;
endpackage

// File: rtl/irq_src_capture.sv
module irq_src_capture #(
   parameter int unsigned         N        = 3,
   parameter logic [N-1:0]        EDGE_SEL = 3'b100
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [N-1:0] pin_i,
   input  logic [N-1:0] clr_i,
   output logic [N-1:0] req_o
);
   for (genvar g = 0; g < N; g++) begin : g_src
      if (EDGE_SEL[g]) begin : g_edge
         logic prev_q, pend_q;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               prev_q <= 1'b0;
               pend_q <= 1'b0;
            end else begin
               prev_q <= pin_i[g];
               pend_q <= (pin_i[g] & ~prev_q) | (pend_q & ~clr_i[g]);
            end
         end
         assign req_o[g] = pend_q;
      end else begin : g_level
         logic unused_clr;
         assign unused_clr = clr_i[g];
         assign req_o[g]   = pin_i[g];
      end
   end
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
   parameter int unsigned           N       = 5,
   parameter int unsigned           VEC_W   = 16,
   parameter logic [N*VEC_W-1:0]    VEC_TAB = '0
) (
   input  logic [N-1:0]     pend_i,
   output logic [N-1:0]     grant_o,
   output logic [VEC_W-1:0] vec_o,
   output logic             any_o
);
   // Slot 0 has the highest priority: scan from the lowest so that it wins last
   always_comb begin
      grant_o = '0;
      vec_o   = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (pend_i[i]) begin
            grant_o    = '0;
            grant_o[i] = 1'b1;
            vec_o      = VEC_TAB[i*VEC_W +: VEC_W];
         end
      end
   end
   assign any_o = |pend_i;
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
   import irq_vec_pkg::*;
#(
   parameter int unsigned VEC_W    = 16,
   parameter int unsigned NMI_VEC  = 32'h0024,
   parameter int unsigned A_VEC    = 32'h002C,
   parameter int unsigned B_VEC    = 32'h0034,
   parameter int unsigned C_VEC    = 32'h003C,
   parameter int unsigned EXT_VEC  = 32'h0000,
   parameter logic [2:0]  EDGE_SEL = 3'b100
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             nmi_i,
   input  logic             irq_a_i,
   input  logic             irq_b_i,
   input  logic             irq_c_i,
   input  logic             ext_req_i,
   input  logic             ien_set_i,
   input  logic             ien_clr_i,
   input  logic             mask_we_i,
   input  logic [2:0]       mask_i,
   input  logic             boundary_i,
   output logic             take_o,
   output logic [VEC_W-1:0] vector_o,
   output logic             ext_ack_o
);
   localparam logic [VEC_W-1:0] V_NMI = VEC_W'(NMI_VEC);
   localparam logic [VEC_W-1:0] V_A   = VEC_W'(A_VEC);
   localparam logic [VEC_W-1:0] V_B   = VEC_W'(B_VEC);
   localparam logic [VEC_W-1:0] V_C   = VEC_W'(C_VEC);
   localparam logic [VEC_W-1:0] V_EXT = VEC_W'(EXT_VEC);
   localparam logic [NUM_SLOT*VEC_W-1:0] VEC_TAB = {V_EXT, V_A, V_B, V_C, V_NMI};

   if (VEC_W < 8 || VEC_W > 32) begin : g_bad_width
      $error("irq_vector_ctrl: VEC_W out of range");
   end
   if (NMI_VEC >= (64'd1 << VEC_W) || A_VEC >= (64'd1 << VEC_W) ||
       B_VEC >= (64'd1 << VEC_W) || C_VEC >= (64'd1 << VEC_W)) begin : g_bad_vec
      $error("irq_vector_ctrl: vector does not fit VEC_W");
   end
   if (NMI_VEC == A_VEC || NMI_VEC == B_VEC || NMI_VEC == C_VEC ||
       A_VEC == B_VEC || A_VEC == C_VEC || B_VEC == C_VEC) begin : g_dup_vec
      $error("irq_vector_ctrl: fixed vectors must differ");
   end

   logic                ien_q;
   logic [NUM_RST-1:0]  mask_q;
   logic [NUM_RST-1:0]  rst_pin, rst_req, rst_clr;
   logic [NUM_SLOT-1:0] pend, grant;
   logic [VEC_W-1:0]    win_vec;
   logic                any_pend, accept, maskable_win;
   logic                take_q, ack_q;
   logic [VEC_W-1:0]    vec_q;

   assign rst_pin = {irq_c_i, irq_b_i, irq_a_i};

   irq_src_capture #(.N(NUM_RST), .EDGE_SEL(EDGE_SEL)) u_capture (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .pin_i (rst_pin),
      .clr_i (rst_clr),
      .req_o (rst_req)
   );

   always_comb begin
      pend           = '0;
      pend[SLOT_NMI] = nmi_i;
      pend[SLOT_C]   = rst_req[2] & ien_q & ~mask_q[2];
      pend[SLOT_B]   = rst_req[1] & ien_q & ~mask_q[1];
      pend[SLOT_A]   = rst_req[0] & ien_q & ~mask_q[0];
      pend[SLOT_EXT] = ext_req_i & ien_q;
   end

   irq_prio_pick #(.N(NUM_SLOT), .VEC_W(VEC_W), .VEC_TAB(VEC_TAB)) u_pick (
      .pend_i (pend),
      .grant_o(grant),
      .vec_o  (win_vec),
      .any_o  (any_pend)
   );

   assign accept       = boundary_i & any_pend;
   assign maskable_win = accept & ~grant[SLOT_NMI];
   assign rst_clr      = {grant[SLOT_C], grant[SLOT_B], grant[SLOT_A]} & {NUM_RST{boundary_i}};

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ien_q  <= 1'b0;
         mask_q <= '1;
         take_q <= 1'b0;
         ack_q  <= 1'b0;
         vec_q  <= '0;
      end else begin
         if (maskable_win || ien_clr_i) ien_q <= 1'b0;
         else if (ien_set_i)            ien_q <= 1'b1;
         if (mask_we_i) mask_q <= mask_i;
         take_q <= accept;
         ack_q  <= accept & grant[SLOT_EXT];
         vec_q  <= accept ? win_vec : '0;
      end
   end

   assign take_o    = take_q;
   assign ext_ack_o = ack_q;
   assign vector_o  = vec_q;
endmodule

// File: rtl/irq_vector_ctrl_chk.sv
module irq_vector_ctrl_chk #(
   parameter int unsigned VEC_W   = 16,
   parameter int unsigned NMI_VEC = 32'h0024
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             nmi_i,
   input logic             boundary_i,
   input logic             take_o,
   input logic [VEC_W-1:0] vector_o,
   input logic             ext_ack_o
);
   localparam logic [VEC_W-1:0] V_NMI = VEC_W'(NMI_VEC);

   // R7
   take_needs_boundary_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !boundary_i |=> !take_o);
   // R4
   ack_with_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ext_ack_o |-> (take_o && vector_o == '0));
   // R1
   idle_vector_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !take_o |-> vector_o == '0);
   // R3
   nmi_always_taken_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (boundary_i && nmi_i) |=> (take_o && vector_o == V_NMI));
   // R8
   no_back_to_back_maskable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (take_o && vector_o != V_NMI) |=> !(take_o && vector_o != V_NMI));
   // R9
   reset_quiet_chk: assert property (@(posedge clk_i)
      !rst_ni |=> (!take_o && !ext_ack_o));
endmodule

bind irq_vector_ctrl irq_vector_ctrl_chk #(.VEC_W(VEC_W), .NMI_VEC(NMI_VEC)) u_chk (
   .clk_i     (clk_i),
   .rst_ni    (rst_ni),
   .nmi_i     (nmi_i),
   .boundary_i(boundary_i),
   .take_o    (take_o),
   .vector_o  (vector_o),
   .ext_ack_o (ext_ack_o)
);

// File: tb/irq_vector_ctrl_bench.sv
module irq_vector_ctrl_bench;
   localparam time CLK_PERIOD = 10ns;

   logic        clk_i = 1'b0;
   logic        rst_ni = 1'b0;
   logic        nmi_i = 0, irq_a_i = 0, irq_b_i = 0, irq_c_i = 0, ext_req_i = 0;
   logic        ien_set_i = 0, ien_clr_i = 0, mask_we_i = 0, boundary_i = 0;
   logic [2:0]  mask_i = '0;
   logic        take_o, ext_ack_o;
   logic [15:0] vector_o;

   int errors = 0;
   int checks = 0;
   bit done = 0;

   irq_vector_ctrl u_irq_vector_ctrl (
      .clk_i(clk_i), .rst_ni(rst_ni), .nmi_i(nmi_i), .irq_a_i(irq_a_i),
      .irq_b_i(irq_b_i), .irq_c_i(irq_c_i), .ext_req_i(ext_req_i),
      .ien_set_i(ien_set_i), .ien_clr_i(ien_clr_i), .mask_we_i(mask_we_i),
      .mask_i(mask_i), .boundary_i(boundary_i), .take_o(take_o),
      .vector_o(vector_o), .ext_ack_o(ext_ack_o)
   );

   always #(CLK_PERIOD/2) clk_i = ~clk_i;

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // Outputs after a boundary: take, vector, ack
   task automatic expect_out(string tag, logic t, logic [15:0] v, logic a);
      check({tag, " take"}, 32'(take_o), 32'(t));
      check({tag, " vector"}, 32'(vector_o), 32'(v));
      check({tag, " ack"}, 32'(ext_ack_o), 32'(a));
   endtask

   task automatic bnd();
      @(negedge clk_i) boundary_i = 1'b1;
      @(negedge clk_i) boundary_i = 1'b0;
   endtask

   task automatic en();
      @(negedge clk_i) ien_set_i = 1'b1;
      @(negedge clk_i) ien_set_i = 1'b0;
   endtask

   task automatic set_mask(logic [2:0] m);
      @(negedge clk_i) begin mask_we_i = 1'b1; mask_i = m; end
      @(negedge clk_i) mask_we_i = 1'b0;
   endtask

   task automatic pulse_c();
      @(negedge clk_i) irq_c_i = 1'b1;
      @(negedge clk_i) irq_c_i = 1'b0;
   endtask

   task automatic t_reset();
      check("R9 take after reset", 32'(take_o), 0);
      check("R9 vector after reset", 32'(vector_o), 0);
      check("R9 ack after reset", 32'(ext_ack_o), 0);
      ext_req_i = 1'b1;
      bnd();
      expect_out("R9 enable clear at reset", 0, 16'h0, 0);
      ext_req_i = 1'b0;
      irq_a_i = 1'b1;
      en();
      bnd();
      expect_out("R9 masks set at reset", 0, 16'h0, 0);
      irq_a_i = 1'b0;
      ext_req_i = 1'b1;
      bnd();
      expect_out("R4 external taken when enabled", 1, 16'h0000, 1);
      @(negedge clk_i);
      check("R7 take one cycle wide", 32'(take_o), 0);
      check("R4 ack one cycle wide", 32'(ext_ack_o), 0);
      bnd();
      expect_out("R8 external accept cleared enable", 0, 16'h0, 0);
      ext_req_i = 1'b0;
   endtask

   task automatic t_nmi();
      nmi_i = 1'b1;
      bnd();
      expect_out("R3 nmi with enable clear", 1, 16'h0024, 0);
      nmi_i = 1'b0;
   endtask

   task automatic t_vectors();
      set_mask(3'b000);
      irq_a_i = 1'b1; en(); bnd();
      expect_out("R1 vector A", 1, 16'h002C, 0);
      irq_a_i = 1'b0;
      irq_b_i = 1'b1; en(); bnd();
      expect_out("R1 vector B", 1, 16'h0034, 0);
      irq_b_i = 1'b0;
      pulse_c(); en(); bnd();
      expect_out("R1 vector C", 1, 16'h003C, 0);
   endtask

   task automatic t_priority();
      irq_a_i = 1'b1; irq_b_i = 1'b1; ext_req_i = 1'b1;
      pulse_c(); en(); bnd();
      expect_out("R2 C over B A ext", 1, 16'h003C, 0);
      en(); bnd();
      expect_out("R2 B over A ext", 1, 16'h0034, 0);
      irq_b_i = 1'b0; en(); bnd();
      expect_out("R2 A over ext", 1, 16'h002C, 0);
      irq_a_i = 1'b0; en(); bnd();
      expect_out("R2 ext last", 1, 16'h0000, 1);
      irq_a_i = 1'b1; nmi_i = 1'b1; en(); bnd();
      expect_out("R2 nmi over all", 1, 16'h0024, 0);
      nmi_i = 1'b0; bnd();
      expect_out("R8 nmi keeps enable", 1, 16'h002C, 0);
      bnd();
      expect_out("R8 maskable accept clears enable", 0, 16'h0, 0);
      irq_a_i = 1'b0; ext_req_i = 1'b0;
   endtask

   task automatic t_mask();
      set_mask(3'b001);
      irq_a_i = 1'b1; en(); bnd();
      expect_out("R5 A blocked by mask bit 0", 0, 16'h0, 0);
      irq_b_i = 1'b1; bnd();
      expect_out("R5 B unblocked", 1, 16'h0034, 0);
      irq_a_i = 1'b0; irq_b_i = 1'b0;
      set_mask(3'b010);
      irq_b_i = 1'b1; en(); bnd();
      expect_out("R5 B blocked by mask bit 1", 0, 16'h0, 0);
      irq_b_i = 1'b0;
      set_mask(3'b000);
   endtask

   task automatic t_edge();
      set_mask(3'b100);
      pulse_c(); en(); bnd();
      expect_out("R6 C pending while masked", 0, 16'h0, 0);
      set_mask(3'b000);
      bnd();
      expect_out("R6 C taken from latch", 1, 16'h003C, 0);
      en(); bnd();
      expect_out("R6 latch cleared by service", 0, 16'h0, 0);
      irq_a_i = 1'b1;
      repeat (3) @(negedge clk_i);
      irq_a_i = 1'b0;
      bnd();
      expect_out("R6 dropped level not held", 0, 16'h0, 0);
   endtask

   task automatic t_boundary();
      irq_a_i = 1'b1;
      for (int i = 0; i < 4; i++) begin
         @(negedge clk_i);
         check("R7 no take without boundary", 32'(take_o), 0);
      end
      bnd();
      expect_out("R7 take after boundary", 1, 16'h002C, 0);
      irq_a_i = 1'b0;
   endtask

   task automatic t_disable();
      en();
      @(negedge clk_i) ien_clr_i = 1'b1;
      @(negedge clk_i) ien_clr_i = 1'b0;
      ext_req_i = 1'b1; bnd();
      expect_out("R10 disable blocks ext", 0, 16'h0, 0);
      @(negedge clk_i) begin ien_set_i = 1'b1; ien_clr_i = 1'b1; end
      @(negedge clk_i) begin ien_set_i = 1'b0; ien_clr_i = 1'b0; end
      bnd();
      expect_out("R10 clear wins over set", 0, 16'h0, 0);
      ext_req_i = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk_i);
      rst_ni = 1'b1;
      @(negedge clk_i);
      t_reset();
      t_nmi();
      t_vectors();
      t_priority();
      t_mask();
      t_edge();
      t_boundary();
      t_disable();
      if (!done) begin
         done = 1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk_i);
      if (!done) begin
         done = 1;
         errors++;
         checks++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule